// File: doc/BRIEF.md
# Dual-Interrupt GPIO Controller with Wakeup

This block controls up to 32 general-purpose pins through a word-wide register port. Each pin is either an input or a driven output, chosen by a direction register. On input pins it watches for rising edges, falling edges, high levels and low levels. Each kind of detection has its own per-pin enable. Any detected event sets the pin's bit in two status banks at the same time. Each bank has its own enable register and its own interrupt line, so two different consumers can each own a subset of the pins.

Level detection keeps its condition asserted. A status bit that software clears while its level still holds is set again on the next clock. Enables, wakeup enables and output data each have set and clear alias addresses, so one bit can be changed without a read-modify-write. A wakeup pulse is produced for events on wakeup-enabled pins, but only while the configuration register selects an idle mode and enables wakeup. Writing the soft-reset bit returns the whole block to its reset state.

Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset every pin is an input, so the direction register reads all ones and `pin_out` is 0. All detect, enable, wakeup-enable, status and output-data registers read 0, `irq_a`, `irq_b` and `wake_req` are low, and the configuration register (0x10) reads 0.
- R2: Three addresses are read-only and ignore writes: 0x00 returns the parameter `REV_ID` (default 0x18), 0x14 returns 1, and 0x38 returns the pin inputs.
- R3: Address 0x38 returns `pin_in` as sampled on the most recent clock edge.
- R4: A rising edge on pin i is seen when the pin is 1 now and was 0 at the previous edge. It sets bit i in both status banks (0x18 and 0x28) at that edge, but only if direction bit i (0x34) is 1, meaning input, and rise-enable bit i (0x48) is 1. A falling edge does the same, gated by fall-enable bit i (0x4c).
- R5: While an input pin is high and its high-level bit (0x44) is 1, or the pin is low and its low-level bit (0x40) is 1, its bit in both status banks is set on every clock. A bit cleared by software under a holding level reads 1 again after the next edge.
- R6: Writing 1s to a status address clears those bits in that bank only. Bits written with 0 are unchanged. An event arriving in the same cycle as a clear of the same bit leaves the bit set.
- R7: `irq_a` is high exactly when bank 0x18 ANDed with enable 0x1c is nonzero. `irq_b` is high exactly when bank 0x28 ANDed with enable 0x2c is nonzero.
- R8: Clear and set aliases act as follows: 0x60/0x64 on enable 0x1c, 0x70/0x74 on enable 0x2c, 0x80/0x84 on wakeup enable 0x20, and 0x90/0x94 on output data 0x3c. A clear alias clears the bits written as 1; a set alias sets them. Reading any alias returns the register it aliases.
- R9: `pin_out[i]` equals output-data bit i when direction bit i is 0, and is 0 when direction bit i is 1.
- R10: The configuration register (0x10) stores the write value ANDed with 0x1d. The control register (0x30) keeps bits 2:0. The debounce-time register (0x54) keeps bits 7:0. The debounce-enable register (0x50) keeps all pin bits.
- R11: A write to 0x10 with bit 1 set returns every register to its R1 value, except that the configuration register then holds the written value ANDed with 0x1d.
- R12: `wake_req` is high for the cycle after each clock edge at which an event hits a pin whose wakeup-enable bit (0x20) is 1. This happens only while configuration bit 2 is 1 and configuration bits 4:3 are nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Driven pin levels, 0 on input pins |
| irq_a | output | 1 | Interrupt request of the first bank |
| irq_b | output | 1 | Interrupt request of the second bank |
| wake_req | output | 1 | One-cycle wakeup pulse |

## Verification
The clash that matters is a software clear of a status bit in the same cycle as a new detection on that bit. The bench provokes it two ways. First, it raises a pin with rise detection enabled in the very cycle that writes 1 to that status bit. Second, it holds a level under level detection while clearing. In both cases the bit must read back as set, while a neighbouring bit cleared in the same write must read 0. A walking-one sweep over all 32 pins also shows that each event lands in both banks, and that clearing one bank leaves the other untouched.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned NBANK  = 2;

   localparam logic [ADDR_W-1:0] A_IDENT    = 8'h00;
   localparam logic [ADDR_W-1:0] A_SYSCFG   = 8'h10;
   localparam logic [ADDR_W-1:0] A_SYSSTAT  = 8'h14;
   localparam logic [ADDR_W-1:0] A_STAT0    = 8'h18;
   localparam logic [ADDR_W-1:0] A_EN0      = 8'h1c;
   localparam logic [ADDR_W-1:0] A_WAKEEN   = 8'h20;
   localparam logic [ADDR_W-1:0] A_STAT1    = 8'h28;
   localparam logic [ADDR_W-1:0] A_EN1      = 8'h2c;
   localparam logic [ADDR_W-1:0] A_CTRL     = 8'h30;
   localparam logic [ADDR_W-1:0] A_DIR      = 8'h34;
   localparam logic [ADDR_W-1:0] A_PINS     = 8'h38;
   localparam logic [ADDR_W-1:0] A_DOUT     = 8'h3c;
   localparam logic [ADDR_W-1:0] A_LVLLO    = 8'h40;
   localparam logic [ADDR_W-1:0] A_LVLHI    = 8'h44;
   localparam logic [ADDR_W-1:0] A_RISE     = 8'h48;
   localparam logic [ADDR_W-1:0] A_FALL     = 8'h4c;
   localparam logic [ADDR_W-1:0] A_DBEN     = 8'h50;
   localparam logic [ADDR_W-1:0] A_DBTIME   = 8'h54;
   localparam logic [ADDR_W-1:0] A_EN0_CLR  = 8'h60;
   localparam logic [ADDR_W-1:0] A_EN0_SET  = 8'h64;
   localparam logic [ADDR_W-1:0] A_EN1_CLR  = 8'h70;
   localparam logic [ADDR_W-1:0] A_EN1_SET  = 8'h74;
   localparam logic [ADDR_W-1:0] A_WAKE_CLR = 8'h80;
   localparam logic [ADDR_W-1:0] A_WAKE_SET = 8'h84;
   localparam logic [ADDR_W-1:0] A_DOUT_CLR = 8'h90;
   localparam logic [ADDR_W-1:0] A_DOUT_SET = 8'h94;

   localparam int unsigned CFG_W    = 5;
   localparam logic [CFG_W-1:0] CFG_KEEP = 5'h1d;
   localparam int unsigned SRST_BIT = 1;
   localparam int unsigned WAKE_BIT = 2;
   localparam int unsigned CTRL_W   = 3;
   localparam int unsigned DBT_W    = 8;

   typedef struct packed {
      logic full;
      logic clr;
      logic set;
   } alias_wr_t;
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
   import gpio_dual_pkg::*;
#(
   parameter int unsigned W = 32,
   parameter logic [31:0] RST_VAL = 32'h0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  alias_wr_t    wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RV = RST_VAL[W-1:0];

   if (W < 1 || W > 32) begin : g_bad_w
      $error("gpio_alias_reg: W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RV;
      else if (srst)    q <= RV;
      else if (wr.full) q <= wdata;
      else if (wr.clr)  q <= q & ~wdata;
      else if (wr.set)  q <= q | wdata;
   end

   // R8: set alias forces every written 1 on
   a_r8_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.set && !wr.full && !wr.clr && !srst) |=> ((q & $past(wdata)) == $past(wdata)));
   // R8: clear alias forces every written 1 off
   a_r8_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.clr && !wr.full && !srst) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_edge_level.sv
module gpio_edge_level #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] dir_in,
   input  logic [NPINS-1:0] rise_en,
   input  logic [NPINS-1:0] fall_en,
   input  logic [NPINS-1:0] lo_en,
   input  logic [NPINS-1:0] hi_en,
   output logic [NPINS-1:0] ev,
   output logic [NPINS-1:0] sampled
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_in;
   end

   assign sampled = prev_q;

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic rise_i, fall_i, lvl_i;
      assign rise_i = pin_in[i] & ~prev_q[i] & rise_en[i];
      assign fall_i = ~pin_in[i] & prev_q[i] & fall_en[i];
      assign lvl_i  = pin_in[i] ? hi_en[i] : lo_en[i];
      assign ev[i]  = dir_in[i] & (rise_i | fall_i | lvl_i);
   end

   // R4: a pin configured as output never raises an event
   a_r4_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev & ~dir_in) == '0));
endmodule

// File: rtl/gpio_status_bank.sv
module gpio_status_bank #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic [NPINS-1:0] ev,
   input  logic             clr_wr,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] en,
   output logic [NPINS-1:0] stat,
   output logic             irq
);
   logic [NPINS-1:0] clr_mask;

   assign clr_mask = clr_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stat <= '0;
      else if (srst) stat <= '0;
      else           stat <= (stat & ~clr_mask) | ev;
   end

   assign irq = |(stat & en);

   // R4 / R5 / R6: every event bit is present after the edge, even under a clear
   a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && (|ev)) |=> ((stat & $past(ev)) == $past(ev)));
   // R6: bits not written with 1 are never lost
   a_r6_keep_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
      !srst |=> ((stat & $past(stat) & ~$past(clr_mask)) == ($past(stat) & ~$past(clr_mask))));
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic [NPINS-1:0] ev,
   input  logic [NPINS-1:0] wake_en,
   input  logic             cfg_ok,
   output logic             wake_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wake_req <= 1'b0;
      else if (srst) wake_req <= 1'b0;
      else           wake_req <= cfg_ok & (|(ev & wake_en));
   end

   // R12: no wakeup unless the idle configuration allowed it at the prior edge
   a_r12_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(cfg_ok) && ((($past(ev) & $past(wake_en)) != '0))));
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
   import gpio_dual_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter logic [31:0] REV_ID = 32'h0000_0018
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic              irq_a,
   output logic              irq_b,
   output logic              wake_req
);
   localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_dual_irq: NPINS must be 1..32");
   end

   logic [NPINS-1:0] wd;
   logic             unused_wdata;
   assign wd           = reg_wdata[NPINS-1:0];
   assign unused_wdata = ^reg_wdata;

   function automatic alias_wr_t dec(input logic [7:0] a, input logic [7:0] full_a,
                                     input logic [7:0] clr_a, input logic [7:0] set_a,
                                     input logic has_alias, input logic we);
      alias_wr_t r;
      r.full = we && (a == full_a);
      r.clr  = we && has_alias && (a == clr_a);
      r.set  = we && has_alias && (a == set_a);
      return r;
   endfunction

   // soft reset strobe
   logic srst;
   assign srst = reg_wr && (reg_addr == A_SYSCFG) && reg_wdata[SRST_BIT];

   // configuration register: loaded on every write, masked
   logic [CFG_W-1:0] syscfg_q;
   gpio_alias_reg #(.W(CFG_W)) u_syscfg (
      .clk(clk), .rst_n(rst_n), .srst(1'b0),
      .wr(dec(reg_addr, A_SYSCFG, A_SYSCFG, A_SYSCFG, 1'b0, reg_wr)),
      .wdata(reg_wdata[CFG_W-1:0] & CFG_KEEP), .q(syscfg_q));

   logic [CTRL_W-1:0] ctrl_q;
   gpio_alias_reg #(.W(CTRL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .wr(dec(reg_addr, A_CTRL, A_CTRL, A_CTRL, 1'b0, reg_wr)),
      .wdata(reg_wdata[CTRL_W-1:0]), .q(ctrl_q));

   logic [DBT_W-1:0] dbtime_q;
   gpio_alias_reg #(.W(DBT_W)) u_dbtime (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .wr(dec(reg_addr, A_DBTIME, A_DBTIME, A_DBTIME, 1'b0, reg_wr)),
      .wdata(reg_wdata[DBT_W-1:0]), .q(dbtime_q));

   // per-pin registers, table-driven
   localparam int unsigned NPREG = 11;
   localparam int unsigned P_DIR = 0, P_DOUT = 1, P_LO = 2, P_HI = 3, P_RISE = 4,
                           P_FALL = 5, P_DBEN = 6, P_WAKE = 7, P_EN0 = 8, P_EN1 = 9,
                           P_SPARE = 10;

   function automatic logic [7:0] preg_addr(input int unsigned k, input int unsigned sel);
      // sel 0: direct, 1: clear alias, 2: set alias
      logic [7:0] base, c, s;
      base = 8'hff; c = 8'hff; s = 8'hff;
      case (k)
         P_DIR:  base = A_DIR;
         P_DOUT: begin base = A_DOUT;   c = A_DOUT_CLR; s = A_DOUT_SET; end
         P_LO:   base = A_LVLLO;
         P_HI:   base = A_LVLHI;
         P_RISE: base = A_RISE;
         P_FALL: base = A_FALL;
         P_DBEN: base = A_DBEN;
         P_WAKE: begin base = A_WAKEEN; c = A_WAKE_CLR; s = A_WAKE_SET; end
         P_EN0:  begin base = A_EN0;    c = A_EN0_CLR;  s = A_EN0_SET;  end
         P_EN1:  begin base = A_EN1;    c = A_EN1_CLR;  s = A_EN1_SET;  end
         default: ;
      endcase
      return (sel == 0) ? base : (sel == 1) ? c : s;
   endfunction

   logic [NPINS-1:0] preg [NPREG];

   for (genvar k = 0; k < NPREG; k++) begin : g_preg
      localparam logic [7:0] FA = preg_addr(k, 0);
      localparam logic [7:0] CA = preg_addr(k, 1);
      localparam logic [7:0] SA = preg_addr(k, 2);
      localparam bit HAS_AL = (CA != 8'hff);
      if (FA == 8'hff) begin : g_none
         assign preg[k] = '0;
      end else begin : g_reg
         gpio_alias_reg #(.W(NPINS), .RST_VAL((k == P_DIR) ? ALL_ONES : 32'h0)) u_r (
            .clk(clk), .rst_n(rst_n), .srst(srst),
            .wr(dec(reg_addr, FA, CA, SA, HAS_AL, reg_wr)),
            .wdata(wd), .q(preg[k]));
      end
   end

   // detection
   logic [NPINS-1:0] ev, sampled;
   gpio_edge_level #(.NPINS(NPINS)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir_in(preg[P_DIR]),
      .rise_en(preg[P_RISE]), .fall_en(preg[P_FALL]),
      .lo_en(preg[P_LO]), .hi_en(preg[P_HI]),
      .ev(ev), .sampled(sampled));

   // two mirrored status banks
   logic [NPINS-1:0] stat [NBANK];
   logic [NBANK-1:0] bank_irq;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [7:0] SA = (b == 0) ? A_STAT0 : A_STAT1;
      gpio_status_bank #(.NPINS(NPINS)) u_bank (
         .clk(clk), .rst_n(rst_n), .srst(srst), .ev(ev),
         .clr_wr(reg_wr && (reg_addr == SA)), .wdata(wd),
         .en(preg[(b == 0) ? P_EN0 : P_EN1]),
         .stat(stat[b]), .irq(bank_irq[b]));
   end

   assign irq_a = bank_irq[0];
   assign irq_b = bank_irq[1];

   // wakeup
   logic cfg_ok;
   assign cfg_ok = syscfg_q[WAKE_BIT] && (syscfg_q[4:3] != 2'b00);

   gpio_wake #(.NPINS(NPINS)) u_wake (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ev(ev),
      .wake_en(preg[P_WAKE]), .cfg_ok(cfg_ok), .wake_req(wake_req));

   // pin drive
   assign pin_out = preg[P_DOUT] & ~preg[P_DIR];

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_IDENT:                          reg_rdata = REV_ID;
         A_SYSCFG:                         reg_rdata = 32'(syscfg_q);
         A_SYSSTAT:                        reg_rdata = 32'h1;
         A_STAT0:                          reg_rdata = 32'(stat[0]);
         A_STAT1:                          reg_rdata = 32'(stat[1]);
         A_EN0, A_EN0_CLR, A_EN0_SET:      reg_rdata = 32'(preg[P_EN0]);
         A_EN1, A_EN1_CLR, A_EN1_SET:      reg_rdata = 32'(preg[P_EN1]);
         A_WAKEEN, A_WAKE_CLR, A_WAKE_SET: reg_rdata = 32'(preg[P_WAKE]);
         A_CTRL:                           reg_rdata = 32'(ctrl_q);
         A_DIR:                            reg_rdata = 32'(preg[P_DIR]);
         A_PINS:                           reg_rdata = 32'(sampled);
         A_DOUT, A_DOUT_CLR, A_DOUT_SET:   reg_rdata = 32'(preg[P_DOUT]);
         A_LVLLO:                          reg_rdata = 32'(preg[P_LO]);
         A_LVLHI:                          reg_rdata = 32'(preg[P_HI]);
         A_RISE:                           reg_rdata = 32'(preg[P_RISE]);
         A_FALL:                           reg_rdata = 32'(preg[P_FALL]);
         A_DBEN:                           reg_rdata = 32'(preg[P_DBEN]);
         A_DBTIME:                         reg_rdata = 32'(dbtime_q);
         default:                          reg_rdata = '0;
      endcase
   end

   // R11: soft reset restores the reset state of direction, enables and status
   a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> ((preg[P_DIR] == '1) && (preg[P_EN0] == '0) && (preg[P_EN1] == '0)
                && (stat[0] == '0) && (stat[1] == '0) && !wake_req));
   // R9: output pins follow the output data written one edge earlier
   a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_DOUT && !srst) |=> ((pin_out | preg[P_DIR]) == ($past(wd) | preg[P_DIR])));
endmodule

// File: tb/gpio_dual_irq_tb.sv
module gpio_dual_irq_tb;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out;
   logic        irq_a, irq_b, wake_req;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_dual_irq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      chk_reg("R1 dir", 8'h34, 32'hFFFF_FFFF);
      chk_reg("R1 stat0", 8'h18, 0);
      chk_reg("R1 stat1", 8'h28, 0);
      chk_reg("R1 syscfg", 8'h10, 0);
      chk_reg("R1 en0", 8'h1c, 0);
      chk("R1 outs", {pin_out, 1'b0, irq_a, irq_b, wake_req}, 0);
      tick();
      chk_reg("R1 rise", 8'h48, 0);
      chk_reg("R1 lvlhi", 8'h44, 0);
      chk_reg("R1 dout", 8'h3c, 0);

      // R2 read-only
      tick();
      chk_reg("R2 ident", 8'h00, 32'h18);
      chk_reg("R2 sysstat", 8'h14, 32'h1);
      wr(8'h00, 32'hDEAD_BEEF);
      wr(8'h14, 32'h0);
      wr(8'h38, 32'hFFFF_FFFF);
      chk_reg("R2 ident after write", 8'h00, 32'h18);
      chk_reg("R2 sysstat after write", 8'h14, 32'h1);
      chk_reg("R2 pins after write", 8'h38, 32'h0);

      // R3 sampled pins
      for (int p = 0; p < 4; p++) begin
         logic [31:0] pat;
         pat = 32'h1357_9BDF * (p + 1) ^ {p[7:0], 24'h0};
         pin_in = pat;
         tick();
         chk_reg("R3 pins", 8'h38, pat);
      end
      pin_in = '0;
      tick();

      // R9 pin drive and R8 data-out aliases
      wr(8'h34, 32'h0000_FFFF);
      wr(8'h3c, 32'hA5A5_5A5A);
      chk("R9 pin_out", pin_out, 32'hA5A5_0000);
      wr(8'h94, 32'h0F0F_000F);
      chk_reg("R8 dout set", 8'h3c, 32'hAFAF_5A5F);
      wr(8'h90, 32'hA000_0002);
      chk_reg("R8 dout clr", 8'h90, 32'h0FAF_5A5D);
      chk("R9 pin_out after alias", pin_out, 32'h0FAF_0000);
      wr(8'h34, 32'hFFFF_FFFF);
      chk("R9 all input", pin_out, 0);
      wr(8'h3c, 0);

      // R4 / R6 walking-one rising sweep
      wr(8'h48, 32'hFFFF_FFFF);
      for (int i = 0; i < N; i++) begin
         logic [31:0] b;
         b = 32'h1 << i;
         pin_in = b;
         tick();
         chk_reg("R4 rise bank0", 8'h18, b);
         chk_reg("R4 rise bank1", 8'h28, b);
         pin_in = '0;
         wr(8'h18, b);
         chk_reg("R6 bank0 cleared", 8'h18, 0);
         chk_reg("R6 bank1 kept", 8'h28, b);
         wr(8'h28, b);
         chk_reg("R6 bank1 cleared", 8'h28, 0);
      end

      // R4 direction gating: pin0 as output
      wr(8'h34, 32'hFFFF_FFFE);
      pin_in = 32'h1;
      tick();
      chk_reg("R4 output pin no event", 8'h18, 0);
      pin_in = '0;
      tick();
      wr(8'h34, 32'hFFFF_FFFF);

      // R4 falling-only on pin3
      wr(8'h48, 0);
      wr(8'h4c, 32'h8);
      pin_in = 32'h8;
      tick();
      chk_reg("R4 rise disabled", 8'h18, 0);
      pin_in = 0;
      tick();
      chk_reg("R4 fall bank0", 8'h18, 32'h8);
      chk_reg("R4 fall bank1", 8'h28, 32'h8);
      wr(8'h4c, 0);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      chk_reg("R6 full clear", 8'h18, 0);

      // R5 high level on pin5
      wr(8'h44, 32'h20);
      pin_in = 32'h20;
      tick();
      chk_reg("R5 high sets", 8'h18, 32'h20);
      wr(8'h18, 32'h20);
      chk_reg("R5 reset after clear", 8'h18, 32'h20);
      pin_in = 0;
      wr(8'h18, 32'h20);
      chk_reg("R5 clears once released", 8'h18, 0);
      wr(8'h44, 0);
      wr(8'h28, 32'hFFFF_FFFF);
      // low level on pin6
      wr(8'h40, 32'h40);
      tick();
      chk_reg("R5 low sets", 8'h28, 32'h40);
      wr(8'h40, 0);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      chk_reg("R5 low cleared", 8'h28, 0);

      // R6 clear and event in the same cycle
      wr(8'h48, 32'h180);
      pin_in = 32'h100;
      tick();
      pin_in = 0;
      tick();
      chk_reg("R6 prep", 8'h18, 32'h100);
      pin_in = 32'h080;
      tick();
      pin_in = 0;
      tick();
      chk_reg("R6 prep both", 8'h18, 32'h180);
      pin_in = 32'h080;
      wr(8'h18, 32'h180);
      chk_reg("R6 event beats clear", 8'h18, 32'h080);
      pin_in = 0;
      wr(8'h48, 0);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);

      // R7 interrupt lines and R8 enable aliases
      wr(8'h48, 32'h4);
      pin_in = 32'h4;
      tick();
      pin_in = 0;
      tick();
      chk("R7 no enable", {irq_a, irq_b}, 2'b00);
      wr(8'h64, 32'h4);
      chk("R7 irq_a only", {irq_a, irq_b}, 2'b10);
      chk_reg("R8 en0 via set alias", 8'h64, 32'h4);
      wr(8'h74, 32'h4);
      chk("R7 both", {irq_a, irq_b}, 2'b11);
      wr(8'h60, 32'h4);
      chk("R7 irq_b only", {irq_a, irq_b}, 2'b01);
      chk_reg("R8 en0 cleared", 8'h1c, 0);
      wr(8'h28, 32'h4);
      chk("R7 status cleared", {irq_a, irq_b}, 2'b00);
      wr(8'h70, 32'hFFFF_FFFF);
      chk_reg("R8 en1 clr", 8'h2c, 0);
      wr(8'h18, 32'hFFFF_FFFF);

      // R10 masked fields
      wr(8'h10, 32'hFFFF_FFFD);
      chk_reg("R10 syscfg mask", 8'h10, 32'h1d);
      wr(8'h30, 32'hFF);
      chk_reg("R10 ctrl", 8'h30, 32'h7);
      wr(8'h54, 32'h1FF);
      chk_reg("R10 dbtime", 8'h54, 32'hFF);
      wr(8'h50, 32'h1234_5678);
      chk_reg("R10 dben", 8'h50, 32'h1234_5678);

      // R11 soft reset
      wr(8'h34, 32'h0F);
      wr(8'h3c, 32'hF0);
      wr(8'h64, 32'h3);
      wr(8'h84, 32'h3);
      wr(8'h10, 32'h6);
      chk_reg("R11 dir", 8'h34, 32'hFFFF_FFFF);
      chk_reg("R11 en0", 8'h1c, 0);
      chk_reg("R11 wake en", 8'h20, 0);
      chk_reg("R11 syscfg", 8'h10, 32'h4);
      tick();
      chk_reg("R11 ctrl", 8'h30, 0);
      chk_reg("R11 dout", 8'h3c, 0);
      chk_reg("R11 dben", 8'h50, 0);

      // R12 wakeup
      wr(8'h10, 32'h0C);
      wr(8'h84, 32'h200);
      wr(8'h48, 32'h600);
      pin_in = 32'h200;
      tick();
      chk("R12 wake pulse", wake_req, 1);
      tick();
      chk("R12 pulse ends", wake_req, 0);
      pin_in = 32'h600;
      tick();
      chk("R12 non-enabled pin", wake_req, 0);
      pin_in = 0;
      tick();
      wr(8'h10, 32'h04);
      pin_in = 32'h200;
      tick();
      chk("R12 idle field zero", wake_req, 0);
      pin_in = 0;
      wr(8'h10, 32'h18);
      pin_in = 32'h200;
      tick();
      chk("R12 wake bit clear", wake_req, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule